// File: doc/BRIEF.md
# Interleaved Binary-Weight PWM Channel

This block is one pulse-width channel that builds its output from eight binary-weighted pulse trains, not from a counter compared against a threshold. A free-running segment counter steps once per tick through a 256-segment cycle. Each data bit owns a train whose length in segments matches that bit's weight. The output is the OR of the trains whose data bit is set. The high time is therefore spread evenly over the cycle, which makes a following low-pass filter much easier to build than with one contiguous pulse.

The host writes an 8-bit level through a simple write strobe, and the new value takes effect at once. A polarity input inverts the waveform. A mode input chooses between the waveform and a plain port level that the host drives directly. A halt input freezes the segment counter, and the tick input comes from an external divider. After reset the output stays low until the first write.

Top module: `bwpwm_top`

## Requirements
- R1: While reset is held and on the first edge after it, `pin_o` is 0. Reset clears the data register and sets the segment counter to 0.
- R2: The segment counter advances by one, from 255 back to 0, on each clock edge where `seg_tick_i` is 1 and `cnt_halt_i` is 0. When `cnt_halt_i` is 1 or `seg_tick_i` is 0, the counter holds its value.
- R3: The train for data bit k (k = 0 for the LSB) is active exactly in the segments c whose lowest set bit is at position 7-k. Bit 7 therefore covers every odd segment and bit 0 covers only segment 128. At most one train is active in any segment, and segment 0 is never high.
- R4: In waveform mode with no inversion, the number of high segments in any 256 consecutive segments equals the data value (0 to 255). A fully high cycle is impossible.
- R5: A write on `wr_en_i` loads `wr_data_i` into the data register on that edge, and the waveform uses the new value from the next segment on. No end-of-cycle latch is involved.
- R6: With `pol_inv_i` = 1 in waveform mode, the output is the complement of the uninverted waveform, so it is high for 256 minus the data value segments per cycle.
- R7: With `pwm_mode_i` = 0, `pin_o` follows `port_val_i`. The data, polarity and counter do not affect it.
- R8: In waveform mode, `pin_o` stays 0 from reset until the first write, whatever the polarity.
- R9: `pin_o` is registered. It shows, one clock after an edge, the value that the counter, data, mode, polarity and port level held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_tick_i | input | 1 | Segment tick enable from the divider |
| cnt_halt_i | input | 1 | 1 freezes the segment counter (count-enable is active low) |
| wr_en_i | input | 1 | Data write strobe |
| wr_data_i | input | 8 | Level to write |
| pol_inv_i | input | 1 | 1 inverts the waveform |
| pwm_mode_i | input | 1 | 1 selects the waveform, 0 selects the port level |
| port_val_i | input | 1 | Plain port output level |
| pin_o | output | 1 | Channel output |

## Verification
Each result is due exactly one clock after the edge that samples its inputs. The output register sees the counter, data, mode, polarity and port level as they stood before that edge, so a write or a tick affects `pin_o` two edges later. The bench keeps a segment-accurate model that it updates on each rising edge, using the same one-edge lag that the requirements specify. It drives inputs and compares `pin_o` with the model on falling edges, so a comparison never races the edge. Duty checks count high samples over 256 consecutive ticks, and that count does not depend on the starting phase of the counter.

// File: rtl/bwpwm_pkg.sv
// Package: shared widths and the pin source selection type for the
// interleaved binary-weight PWM channel.
package bwpwm_pkg;

    // Width of the data value and of the segment counter
    localparam int unsigned BW_DATA_W = 8;

    // What drives the output pin in a given cycle
    typedef enum logic [1:0] {
        PIN_SRC_PORT = 2'd0,
        PIN_SRC_WAVE = 2'd1,
        PIN_SRC_IDLE = 2'd2
    } pin_src_e;

endpackage

// File: rtl/bwpwm_segcnt.sv
// Module: bwpwm_segcnt
// Segment counter. It steps once per enabled tick and wraps naturally at
// 2**W. Assumes the tick is a one-cycle enable from an external divider
// and that halt is the active-high form of the count-enable control.
module bwpwm_segcnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         halt_i,
    output logic [W-1:0] cnt_o
);

    logic step;

    // Decide whether this edge advances the counter
    always_comb begin
        step = tick_i && !halt_i;
    end

    // Hold or advance the segment counter, clearing it on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (step) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !halt_i) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i || halt_i) |=> $stable(cnt_o)); // R2

endmodule

// File: rtl/bwpwm_weave.sv
// Module: bwpwm_weave
// Builds one pulse train per data bit and ORs together the trains that are
// enabled. Train k is active in the segments whose lowest set bit is at
// position W-1-k, so it covers 2**k segments per cycle. Purely
// combinational; clk and rst_n serve only the assertions.
module bwpwm_weave #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] data_i,
    output logic         pulse_o
);

    logic [W-1:0] train;

    for (genvar k = 0; k < W; k++) begin : g_train
        localparam int unsigned POS = W - 1 - k;
        localparam logic [W-1:0] LOW_MASK = ({{(W-1){1'b0}}, 1'b1} << POS) - 1'b1;
        // Train k: bit POS set and every bit below it clear
        always_comb begin
            train[k] = cnt_i[POS] && ((cnt_i & LOW_MASK) == '0);
        end
    end

    // OR of the trains that their data bits enable
    always_comb begin
        pulse_o = |(train & data_i);
    end

    AST_TRAIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(train)); // R3
    AST_SEG0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |-> !pulse_o); // R3
    AST_ZERO_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (data_i == '0) |-> !pulse_o); // R4

endmodule

// File: rtl/bwpwm_outsel.sv
// Module: bwpwm_outsel
// Output stage. It picks the port level, the (optionally inverted)
// waveform, or a forced low before the first write, and registers the
// result. Assumes every select input is synchronous to clk.
module bwpwm_outsel
    import bwpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic pulse_i,
    input  logic pol_inv_i,
    input  logic pwm_mode_i,
    input  logic port_val_i,
    output logic pin_o
);

    pin_src_e src;
    logic     pin_d;

    // Choose the pin source for this cycle
    always_comb begin
        if (!pwm_mode_i) begin
            src = PIN_SRC_PORT;
        end else if (!armed_i) begin
            src = PIN_SRC_IDLE;
        end else begin
            src = PIN_SRC_WAVE;
        end
    end

    // Form the next pin level from the chosen source
    always_comb begin
        unique case (src)
            PIN_SRC_PORT: pin_d = port_val_i;
            PIN_SRC_WAVE: pin_d = pulse_i ^ pol_inv_i;
            default:      pin_d = 1'b0;
        endcase
    end

    // Register the pin so that it never glitches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o <= 1'b0;
        end else begin
            pin_o <= pin_d;
        end
    end

    AST_PORT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_mode_i |=> (pin_o == $past(port_val_i))); // R7
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_i && !armed_i) |=> !pin_o); // R8
    AST_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_i && armed_i) |=> (pin_o == ($past(pulse_i) ^ $past(pol_inv_i)))); // R6

endmodule

// File: rtl/bwpwm_top.sv
// Module: bwpwm_top
// One interleaved binary-weight PWM channel. It holds the written level,
// a flag that records the first write, the segment counter, the pulse
// weaver and the registered output stage. A write takes effect at once,
// with no end-of-cycle latch. Assumes the host writes synchronously to clk.
module bwpwm_top
    import bwpwm_pkg::*;
#(
    parameter int unsigned DW = BW_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seg_tick_i,
    input  logic          cnt_halt_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          pol_inv_i,
    input  logic          pwm_mode_i,
    input  logic          port_val_i,
    output logic          pin_o
);

    logic [DW-1:0] level_q;
    logic          armed_q;
    logic [DW-1:0] seg_cnt;
    logic          pulse;

    // Load the level on a write; the first write arms the waveform
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            armed_q <= 1'b0;
        end else if (wr_en_i) begin
            level_q <= wr_data_i;
            armed_q <= 1'b1;
        end
    end

    bwpwm_segcnt #(.W(DW)) i_segcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (seg_tick_i),
        .halt_i (cnt_halt_i),
        .cnt_o  (seg_cnt)
    );

    bwpwm_weave #(.W(DW)) i_weave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (seg_cnt),
        .data_i  (level_q),
        .pulse_o (pulse)
    );

    bwpwm_outsel i_outsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed_i    (armed_q),
        .pulse_i    (pulse),
        .pol_inv_i  (pol_inv_i),
        .pwm_mode_i (pwm_mode_i),
        .port_val_i (port_val_i),
        .pin_o      (pin_o)
    );

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (level_q == $past(wr_data_i))); // R5
    AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(level_q)); // R5
    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !pin_o); // R1

endmodule

// File: tb/test_bwpwm_top.sv
// Directed bench for bwpwm_top. A segment-accurate model is updated on
// each rising edge; inputs change and outputs are sampled on falling edges.
module test_bwpwm_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seg_tick_i = 1'b0;
    logic       cnt_halt_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       pol_inv_i = 1'b0;
    logic       pwm_mode_i = 1'b1;
    logic       port_val_i = 1'b0;
    logic       pin_o;

    int checks = 0;
    int fails = 0;

    int mc = 0;
    int md = 0;
    bit marm = 1'b0;
    bit exp_pin = 1'b0;

    always #5 clk = ~clk;

    bwpwm_top i_bwpwm_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg_tick_i (seg_tick_i),
        .cnt_halt_i (cnt_halt_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .pol_inv_i  (pol_inv_i),
        .pwm_mode_i (pwm_mode_i),
        .port_val_i (port_val_i),
        .pin_o      (pin_o)
    );

    // Level of the weighted pulse sum in segment c for data d (R3, R4)
    function automatic bit ref_level(int c, int d);
        int tz = 0;
        if (c == 0) return 1'b0;
        while (((c >> tz) & 1) == 0) tz++;
        return bit'((d >> (7 - tz)) & 1);
    endfunction

    // Reference model: pin value due after this edge, then state update
    always @(posedge clk) begin
        if (!rst_n) begin
            mc = 0; md = 0; marm = 1'b0; exp_pin = 1'b0;
        end else begin
            if (!pwm_mode_i) exp_pin = port_val_i;
            else if (!marm)  exp_pin = 1'b0;
            else             exp_pin = ref_level(mc, md) ^ pol_inv_i;
            if (wr_en_i) begin md = int'(wr_data_i); marm = 1'b1; end
            if (seg_tick_i && !cnt_halt_i) mc = (mc + 1) % 256;
        end
    end

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Compare pin with the model for n cycles; one check for the window
    task automatic run_match(int n, string req);
        int bad = 0;
        int act = 0;
        int expv = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_o !== exp_pin) begin
                if (bad == 0) begin act = int'(pin_o); expv = int'(exp_pin); end
                bad++;
            end
        end
        check(bad == 0, req, act, expv);
    endtask

    task automatic write_level(logic [7:0] v);
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // R1, R8: reset state and idle-low before the first write
    task automatic t_reset();
        rst_n = 1'b0; seg_tick_i = 1'b1; pwm_mode_i = 1'b1; pol_inv_i = 1'b1;
        repeat (3) @(negedge clk);
        check(pin_o == 1'b0, "R1 pin low in reset", int'(pin_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_o == 1'b0, "R1 pin low after reset", int'(pin_o), 0);
        run_match(300, "R8 idle low before write (inverted)");
        pol_inv_i = 1'b0;
    endtask

    // R3, R4, R5: duty count over 256 ticks and cycle-exact pattern
    task automatic t_duty(logic [7:0] v, bit inv, int exp_high, string req);
        int high = 0;
        int bad = 0;
        pol_inv_i = inv; seg_tick_i = 1'b1; cnt_halt_i = 1'b0; pwm_mode_i = 1'b1;
        write_level(v);
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (pin_o) high++;
            if (pin_o !== exp_pin) bad++;
        end
        check(high == exp_high, req, high, exp_high);
        check(bad == 0, "R3 segment pattern matches weights", bad, 0);
    endtask

    // R5: write mid-cycle takes effect without waiting for cycle end
    task automatic t_midwrite();
        pol_inv_i = 1'b0; seg_tick_i = 1'b1;
        write_level(8'h80);
        repeat (37) @(negedge clk);
        write_level(8'h00);
        @(negedge clk);
        check(pin_o == 1'b0, "R5 immediate transfer to zero", int'(pin_o), 0);
        run_match(20, "R5 zero level stays low");
        write_level(8'h80);
        run_match(60, "R5 new level used at once");
    endtask

    // R2: halt and missing ticks freeze the counter, and so the pin
    task automatic t_halt();
        int changes = 0;
        bit first;
        write_level(8'hAA);
        repeat (5) @(negedge clk);
        cnt_halt_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        first = pin_o;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pin_o != first) changes++;
        end
        check(changes == 0, "R2 halt freezes output", changes, 0);
        cnt_halt_i = 1'b0;
        run_match(40, "R2 count resumes after halt");
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            seg_tick_i = (i % 3) == 0;
            if (pin_o !== exp_pin) check(1'b0, "R2 sparse ticks", int'(pin_o), int'(exp_pin));
        end
        seg_tick_i = 1'b1;
        checks++;
    endtask

    // R7, R9: port mode follows the port level one clock later
    task automatic t_port();
        int bad = 0;
        pwm_mode_i = 1'b0; pol_inv_i = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            port_val_i = (i % 4) < 2;
            wr_en_i = (i == 10); wr_data_i = 8'h3C;
            @(posedge clk);
            @(negedge clk);
            if (pin_o !== port_val_i) bad++;
        end
        wr_en_i = 1'b0;
        check(bad == 0, "R7 port mode follows port level", bad, 0);
        check(pin_o == exp_pin, "R9 registered port level", int'(pin_o), int'(exp_pin));
        pwm_mode_i = 1'b1; pol_inv_i = 1'b0;
        run_match(40, "R9 back to waveform mode");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_duty(8'h00, 1'b0, 0,   "R4 duty for 0");
        t_duty(8'h01, 1'b0, 1,   "R4 duty for 1 (segment 128 only)");
        t_duty(8'h80, 1'b0, 128, "R4 duty for 0x80 (odd segments)");
        t_duty(8'h55, 1'b0, 85,  "R4 duty for 0x55");
        t_duty(8'hFF, 1'b0, 255, "R4 duty for 0xFF never fully high");
        t_duty(8'h40, 1'b1, 192, "R6 inverted duty for 0x40");
        t_midwrite();
        t_halt();
        t_port();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule